// File: doc/BRIEF.md
# Guarded Configuration Register Bank

This block holds seven system configuration registers whose writes are filtered bit by bit. Three inputs drive the filter: an operating mode captured from two strap pins while reset is held, a short window of clock cycles that opens when reset ends, and a per-register flag that records whether the register has already been written. Some bits accept one write only. Some accept one write only while the window is open. Some can only be set, with clearing allowed just once. A special mode lifts most of these limits.

Software reaches the bank through a single-cycle synchronous port. It has an address, write data and a write strobe, and the read data is combinational. The captured mode and the window state are brought out as pins so that nearby logic can use them. The external reset is asynchronous and active low. Inside the block it is released through a two-stage synchronizer. Cycle 0 of the window is the first clock cycle after that internal release, which comes two rising edges after `rst_n` goes high.

Top module: `cfg_guard_bank`

## Requirements
- R1: While reset is held, the strap pins are captured every cycle. `op_mode` = {special, mode-A}, where special = NOT `mode_b_pin` and mode-A = `mode_a_pin`. The codes are 00 single-chip, 01 expanded, 10 bootstrap and 11 test. Special mode means `op_mode[1]`=1.
- R2: Once the internal reset has been released, changes on the strap pins do not change `op_mode`.
- R3: `window_open` is 1 from cycle 0 through cycle 63 after the internal reset release. From cycle 64 it is 0 until the next reset. A write made in cycle 64 or later counts as outside the window.
- R4: Register 0 (timer mask). Outside special mode, bits 1:0 are taken only if the write is the first one to this register and falls inside the window; otherwise they keep their value. Bits 7:2 are taken on every write.
- R5: In special mode, the window-limited bits of registers 0, 5 and 6 accept any number of writes at any time.
- R6: Register 1 (display control). Bit 0 is taken only on the first write to the register. Bits 7:1 are taken on every write.
- R7: Register 2 (block protect). A write ORs the data into the register. A full overwrite, which can clear bits, happens only in special mode, or on the first write to the register when that write falls inside the window.
- R8: Register 3 (memory map) is taken whole on its first write, at any time and in any mode. Later writes are ignored.
- R9: Register 4 (options 2). Bits 1:0 are taken only on the first write in every mode. Bit 4 is taken only on the first write outside special mode, and on every write in special mode. Bits 7:5, 3 and 2 are taken on every write.
- R10: Register 5 (options). Outside special mode, bits 5, 4, 2, 1 and 0 are taken only on the first write to the register inside the window. Bits 7, 6 and 3 are taken on every write.
- R11: Register 6 (RAM/IO map). Outside special mode, the whole register is taken only on the first write inside the window.
- R12: The first write addressed to a register uses up its one-write allowance. This holds even if the write changes no bit or falls outside the window.
- R13: Reset loads the defaults: reg0=0x00, reg1=0x00, reg2=0x1F, reg3=0x01, reg4=0x00, reg5=0x10, reg6=0x01. `rdata` always shows the addressed register. Address 7 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_a_pin | input | 1 | Strap pin A, captured during reset |
| mode_b_pin | input | 1 | Strap pin B, captured during reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Contents of the addressed register |
| op_mode | output | 2 | Captured mode {special, mode-A} |
| window_open | output | 1 | High during the post-reset write window |

## Verification
The bound checker watches several behaviours on every cycle: the mode stays frozen after reset, the window closes exactly once after 63 counts and stays closed, and the window-limited bits of registers 0, 5 and 6 never move outside special mode after the window has closed. It also checks that block-protect bits never clear once the window has closed outside special mode, and that the memory-map register never changes after its first write. Other behaviours depend on a particular sequence of writes, so only the directed scenarios can show them. These are the first-write allowance being used up by a write that changes nothing, the exact boundary between cycle 63 and cycle 64, special mode lifting the limits, and the mixed per-bit rules of registers 1 and 4.

// File: rtl/cfg_guard_pkg.sv
`timescale 1ns/1ps
package cfg_guard_pkg;
  localparam int DATA_W = 8;
  localparam int NREG   = 7;
  localparam int ADDR_W = 3;

  localparam int SLOT_TMASK = 0;
  localparam int SLOT_DISP  = 1;
  localparam int SLOT_BPROT = 2;
  localparam int SLOT_MEMAP = 3;
  localparam int SLOT_OPT2  = 4;
  localparam int SLOT_OPT   = 5;
  localparam int SLOT_RIMAP = 6;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_EXPANDED = 2'b01,
    MODE_BOOT     = 2'b10,
    MODE_TEST     = 2'b11
  } op_mode_e;

  // Per-bit write classes; the masks of one slot are disjoint.
  typedef struct packed {
    logic [DATA_W-1:0] free;       // any write
    logic [DATA_W-1:0] once;       // first write, all modes
    logic [DATA_W-1:0] once_nspec; // first write unless special
    logic [DATA_W-1:0] win;        // first write in window unless special
    logic [DATA_W-1:0] setonly;    // OR-in; overwrite under window rule
    logic [DATA_W-1:0] rst;        // reset value
  } slot_rule_t;

  function automatic slot_rule_t rule_of(int idx);
    slot_rule_t r;
    r = '0;
    case (idx)
      SLOT_TMASK: begin r.win = 8'h03; r.free = 8'hFC; r.rst = 8'h00; end
      SLOT_DISP:  begin r.once = 8'h01; r.free = 8'hFE; r.rst = 8'h00; end
      SLOT_BPROT: begin r.setonly = 8'hFF; r.rst = 8'h1F; end
      SLOT_MEMAP: begin r.once = 8'hFF; r.rst = 8'h01; end
      SLOT_OPT2:  begin r.once = 8'h03; r.once_nspec = 8'h10; r.free = 8'hEC; r.rst = 8'h00; end
      SLOT_OPT:   begin r.win = 8'h37; r.free = 8'hC8; r.rst = 8'h10; end
      SLOT_RIMAP: begin r.win = 8'hFF; r.rst = 8'h01; end
      default:    r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
`timescale 1ns/1ps
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_mode_latch.sv
`timescale 1ns/1ps
module cfg_mode_latch (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic pin_a,
  input  logic pin_b,
  output logic special,
  output logic mode_a
);
  logic       cap_en;
  logic [1:0] mode_q;
  logic [1:0] mode_d;

  // Straps are sampled only while the internal reset is held.
  always_comb begin
    cap_en = ~rst_sync_n;
    mode_d = cap_en ? {~pin_b, pin_a} : mode_q;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign special = mode_q[1];
  assign mode_a  = mode_q[0];
endmodule

// File: rtl/cfg_window_timer.sv
`timescale 1ns/1ps
module cfg_window_timer #(
  parameter int WINDOW = 64,
  parameter int CNT_W  = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  output logic             window_open,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_q != CNT_W'(WINDOW));
    cnt_d  = cnt_en ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign window_open = (cnt_q < CNT_W'(WINDOW));
  assign cnt         = cnt_q;
endmodule

// File: rtl/cfg_reg_slot.sv
`timescale 1ns/1ps
module cfg_reg_slot
  import cfg_guard_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              sel_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              special,
  input  logic              window_open,
  output logic [DATA_W-1:0] q,
  output logic              used
);
  localparam slot_rule_t RULE = rule_of(IDX);

  logic [DATA_W-1:0] q_r, q_d, ok_mask, plain_v, set_v;
  logic              used_q, used_d, first_ok, win_ok;

  always_comb begin
    first_ok = ~used_q;
    win_ok   = special | (window_open & ~used_q);
    ok_mask  = RULE.free
             | (RULE.once       & {DATA_W{first_ok}})
             | (RULE.once_nspec & {DATA_W{special | first_ok}})
             | (RULE.win        & {DATA_W{win_ok}});
    plain_v  = (q_r & ~ok_mask) | (wdata & ok_mask);
    set_v    = win_ok ? wdata : (q_r | wdata);
    q_d      = sel_we ? ((plain_v & ~RULE.setonly) | (set_v & RULE.setonly)) : q_r;
    used_d   = used_q | sel_we;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_r    <= RULE.rst;
      used_q <= 1'b0;
    end else begin
      q_r    <= q_d;
      used_q <= used_d;
    end
  end

  assign q    = q_r;
  assign used = used_q;
endmodule

// File: rtl/cfg_guard_bank.sv
`timescale 1ns/1ps
module cfg_guard_bank
  import cfg_guard_pkg::*;
#(
  parameter int WINDOW      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_a_pin,
  input  logic              mode_b_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        op_mode,
  output logic              window_open
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic              rst_sync_n;
  logic              special, mode_a;
  logic [CNT_W-1:0]  win_cnt;
  logic [DATA_W-1:0] reg_q [NREG];
  logic [NREG-1:0]   used_q;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cfg_mode_latch u_mode (
    .clk(clk), .rst_sync_n(rst_sync_n), .pin_a(mode_a_pin), .pin_b(mode_b_pin),
    .special(special), .mode_a(mode_a)
  );

  cfg_window_timer #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_sync_n(rst_sync_n), .window_open(window_open), .cnt(win_cnt)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (addr == ADDR_W'(i));
    cfg_reg_slot #(.IDX(i)) u_slot (
      .clk(clk), .rst_sync_n(rst_sync_n), .sel_we(sel), .wdata(wdata),
      .special(special), .window_open(window_open),
      .q(reg_q[i]), .used(used_q[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) rdata = reg_q[i];
    end
  end

  assign op_mode = {special, mode_a};
endmodule

// File: rtl/cfg_guard_checker.sv
`timescale 1ns/1ps
module cfg_guard_checker #(
  parameter int WINDOW = 64,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [1:0]       op_mode,
  input logic             window_open,
  input logic [CNT_W-1:0] win_cnt,
  input logic [7:0]       tmask_q,
  input logic [7:0]       bprot_q,
  input logic [7:0]       memap_q,
  input logic             memap_used,
  input logic [7:0]       opt_q,
  input logic [7:0]       rimap_q
);
  logic locked;
  assign locked = !op_mode[1] && !window_open;

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> $stable(op_mode));

  assert_window_stays_shut_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !window_open |=> !window_open);

  assert_window_length_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(window_open) |-> ($past(win_cnt) == CNT_W'(WINDOW - 1)));

  assert_tmask_lock_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |=> $stable(tmask_q[1:0]));

  assert_bprot_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |=> ((bprot_q & $past(bprot_q)) == $past(bprot_q)));

  assert_memap_once_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    memap_used |=> $stable(memap_q));

  assert_opt_lock_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |=> ($stable(opt_q[5:4]) && $stable(opt_q[2:0])));

  assert_rimap_lock_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |=> $stable(rimap_q));
endmodule

bind cfg_guard_bank cfg_guard_checker #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .op_mode(op_mode), .window_open(window_open),
  .win_cnt(win_cnt), .tmask_q(reg_q[0]), .bprot_q(reg_q[2]), .memap_q(reg_q[3]),
  .memap_used(used_q[3]), .opt_q(reg_q[5]), .rimap_q(reg_q[6])
);

// File: tb/tb_cfg_guard_bank.sv
`timescale 1ns/1ps
module tb_cfg_guard_bank;
  logic       clk, rst_n, mode_a_pin, mode_b_pin, wr_en;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic [1:0] op_mode;
  logic       window_open;
  int n_cmp, n_bad;

  cfg_guard_bank dut (
    .clk(clk), .rst_n(rst_n), .mode_a_pin(mode_a_pin), .mode_b_pin(mode_b_pin),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .op_mode(op_mode), .window_open(window_open)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, int a, logic [7:0] exp);
    addr = 3'(a);
    #1;
    cmp(tag, rdata, exp);
  endtask

  // Leaves the bench at the falling edge that opens window cycle 0.
  task automatic do_reset(logic ma, logic mb);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; mode_a_pin = ma; mode_b_pin = mb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    addr = 3'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_defaults;
    do_reset(1'b0, 1'b1);
    rd("R13 reg0 default", 0, 8'h00);
    rd("R13 reg1 default", 1, 8'h00);
    rd("R13 reg2 default", 2, 8'h1F);
    rd("R13 reg3 default", 3, 8'h01);
    rd("R13 reg4 default", 4, 8'h00);
    rd("R13 reg5 default", 5, 8'h10);
    rd("R13 reg6 default", 6, 8'h01);
    rd("R13 addr7 reads zero", 7, 8'h00);
    cmp("R3 window open at cycle 0", {7'd0, window_open}, 8'h01);
  endtask

  task automatic t_mode_capture;
    for (int k = 0; k < 4; k++) begin
      logic ma, mb;
      ma = k[0]; mb = k[1];
      do_reset(ma, mb);
      cmp("R1 mode capture", {6'd0, op_mode}, {6'd0, ~mb, ma});
    end
  endtask

  task automatic t_pins_ignored;
    do_reset(1'b1, 1'b1);
    mode_a_pin = 1'b0; mode_b_pin = 1'b0;
    idle(4);
    cmp("R2 pins ignored after reset", {6'd0, op_mode}, 8'h01);
  endtask

  task automatic t_tmask_normal;
    do_reset(1'b0, 1'b1);
    wr(0, 8'hFF);
    rd("R4 first write in window", 0, 8'hFF);
    wr(0, 8'h00);
    rd("R4 low bits locked, high bits free", 0, 8'h03);
    idle(70);
    wr(0, 8'h80);
    rd("R4 after window", 0, 8'h83);
    do_reset(1'b0, 1'b1);
    wr(0, 8'h00);
    wr(0, 8'h03);
    rd("R12 unchanged write consumes once", 0, 8'h00);
  endtask

  task automatic t_window_edge;
    do_reset(1'b0, 1'b1);
    idle(63);
    cmp("R3 open at cycle 63", {7'd0, window_open}, 8'h01);
    wr(0, 8'h03);
    rd("R3 write at cycle 63 taken", 0, 8'h03);
    do_reset(1'b0, 1'b1);
    idle(64);
    cmp("R3 closed at cycle 64", {7'd0, window_open}, 8'h00);
    wr(0, 8'h03);
    rd("R3 write at cycle 64 refused", 0, 8'h00);
  endtask

  task automatic t_special;
    do_reset(1'b0, 1'b0);
    idle(70);
    wr(0, 8'h03);
    rd("R5 special reg0 late write", 0, 8'h03);
    wr(0, 8'h01);
    rd("R5 special reg0 rewrite", 0, 8'h01);
    wr(6, 8'h0A);
    wr(6, 8'h05);
    rd("R5 special reg6 rewrite", 6, 8'h05);
    wr(5, 8'h37);
    rd("R5 special reg5 late write", 5, 8'h37);
    wr(5, 8'h00);
    rd("R5 special reg5 rewrite", 5, 8'h00);
  endtask

  task automatic t_disp;
    do_reset(1'b0, 1'b1);
    wr(1, 8'h01);
    wr(1, 8'hF0);
    rd("R6 bit0 once, upper free", 1, 8'hF1);
  endtask

  task automatic t_bprot;
    do_reset(1'b0, 1'b1);
    idle(70);
    wr(2, 8'h00);
    rd("R7 clear refused after window", 2, 8'h1F);
    wr(2, 8'h20);
    rd("R7 set accepted after window", 2, 8'h3F);
    do_reset(1'b0, 1'b1);
    wr(2, 8'h00);
    rd("R7 first clear in window", 2, 8'h00);
    wr(2, 8'h04);
    wr(2, 8'h00);
    rd("R7 second clear refused", 2, 8'h04);
    do_reset(1'b0, 1'b0);
    idle(70);
    wr(2, 8'h00);
    rd("R7 special clear late", 2, 8'h00);
  endtask

  task automatic t_memap;
    do_reset(1'b0, 1'b1);
    idle(70);
    wr(3, 8'h05);
    rd("R8 first write late", 3, 8'h05);
    wr(3, 8'h0A);
    rd("R8 second write ignored", 3, 8'h05);
    do_reset(1'b0, 1'b0);
    wr(3, 8'h01);
    wr(3, 8'h0F);
    rd("R12 same-value write uses once (special)", 3, 8'h01);
  endtask

  task automatic t_opt2;
    do_reset(1'b0, 1'b1);
    wr(4, 8'h13);
    wr(4, 8'hEC);
    rd("R9 normal locks bits 4,1,0", 4, 8'hFF);
    do_reset(1'b0, 1'b0);
    wr(4, 8'h13);
    wr(4, 8'h00);
    rd("R9 special bit4 free, 1:0 locked", 4, 8'h03);
  endtask

  task automatic t_opt;
    do_reset(1'b0, 1'b1);
    wr(5, 8'hFF);
    wr(5, 8'h00);
    rd("R10 guarded bits held", 5, 8'h37);
    do_reset(1'b0, 1'b1);
    idle(70);
    wr(5, 8'hFF);
    rd("R10 late write only free bits", 5, 8'hD8);
  endtask

  task automatic t_rimap;
    do_reset(1'b0, 1'b1);
    wr(6, 8'h0A);
    wr(6, 8'h05);
    rd("R11 once in window", 6, 8'h0A);
    do_reset(1'b1, 1'b1);
    idle(70);
    wr(6, 8'h0A);
    rd("R11 late write refused", 6, 8'h01);
  endtask

  task automatic t_unmapped;
    do_reset(1'b0, 1'b1);
    wr(7, 8'hFF);
    rd("R13 addr7 still zero", 7, 8'h00);
    rd("R13 reg0 untouched by addr7", 0, 8'h00);
    rd("R13 reg6 untouched by addr7", 6, 8'h01);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    mode_a_pin = 1'b0; mode_b_pin = 1'b1;
    t_defaults();
    t_mode_capture();
    t_pins_ignored();
    t_tmask_normal();
    t_window_edge();
    t_special();
    t_disp();
    t_bprot();
    t_memap();
    t_opt2();
    t_opt();
    t_rimap();
    t_unmapped();
    summary();
    $finish;
  end
endmodule